// File: doc/BRIEF.md
# Fault Flash-Cadence Indicator

This block drives a single active-low alarm LED so that an operator can read the most serious fault present from the number of flashes. Each fault has a fixed rank. The LED shows the highest-ranked fault as a burst of that many flashes, followed by a dark pause, and the burst repeats while the fault remains.

When no fault is present but an external squelch override is active, the LED stays lit continuously. When nothing is active at all, the LED stays dark. All timing is counted in ticks of a slow enable input, so the same logic serves any system clock.

The fault to show is captured at the start of each burst and held for that whole burst and its pause. A fault flag that changes part-way through a burst therefore cannot produce a miscounted pattern. A change takes effect only on the tick that ends the pause.

Top module: `fault_cadence_led`

## Requirements
- R1: Fault bit 4 (synthesizer unlocked) has the highest rank and is shown as five flashes per burst.
- R2: Fault bit k is shown as k+1 flashes per burst. Bit 3 is tuning voltage out of range, bit 2 is low signal strength, bit 1 is channel unprogrammed or out of range, and bit 0 is low supply voltage.
- R3: When several fault bits are set, only the highest-numbered set bit sets the flash count.
- R4: Each flash is lit for FLASH_TICKS ticks and then dark for FLASH_TICKS ticks. After the last flash of a burst, the LED stays dark for PAUSE_TICKS ticks before the next burst begins.
- R5: With no fault bit set and `ext_squelch` high, the LED is lit continuously.
- R6: With no fault bit set and `ext_squelch` low, the LED is dark.
- R7: The flash count is captured when a burst starts. Changing the fault bits during a burst or its pause has no effect until the tick that ends the pause.
- R8: `led_n` is active low (0 = lit), and it is 1 during and directly after reset.
- R9: The cadence advances only on cycles where `tick` is high. A fault that appears while the LED is idle starts its burst on the next tick.
- R10: While a fault burst or its pause is being shown, `ext_squelch` has no effect on the LED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle cadence time-base enable |
| faults | input | NUM_FAULTS | Fault flags; a higher bit index has a higher rank |
| ext_squelch | input | 1 | External squelch active; requests steady-on when no fault is set |
| led_n | output | 1 | Active-low LED drive, registered |

## Verification
A wrong captured flash count shows at the port within one burst period, as an extra or missing lit slot before the pause. A timer that ends a phase early or late shifts every later edge, so the first lit-to-dark transition after the fault already reveals it. A sequencer stuck outside the idle phase shows as a LED that fails to go steady-on once the faults clear and the pause ends, one pause length later. The bench compares every tick slot against a period computed arithmetically from the flash count, so any of these faults is caught in the slot where it first appears.

// File: rtl/fault_cadence_pkg.sv
package fault_cadence_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ON    = 2'd1,
    PH_OFF   = 2'd2,
    PH_PAUSE = 2'd3
  } phase_t;
endpackage

// File: rtl/fc_prio_enc.sv
// Highest set flag wins; the output code is its index plus one, and 0 means no flag.
module fc_prio_enc #(
  parameter int NUM_FAULTS = 5,
  localparam int CW = $clog2(NUM_FAULTS + 1)
) (
  input  logic [NUM_FAULTS-1:0] faults,
  output logic [CW-1:0]         code,
  output logic                  any_fault
);
  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_FAULTS; i++) begin
      if (faults[i]) code = CW'(i + 1);
    end
  end
  assign any_fault = |faults;
endmodule

// File: rtl/fc_cadence_seq.sv
// Burst sequencer: flash ON, flash OFF (repeated), then pause; advances on tick only.
module fc_cadence_seq
  import fault_cadence_pkg::*;
#(
  parameter int NUM_FAULTS  = 5,
  parameter int FLASH_TICKS = 4,
  parameter int PAUSE_TICKS = 12,
  localparam int CW   = $clog2(NUM_FAULTS + 1),
  localparam int TMAX = (FLASH_TICKS > PAUSE_TICKS) ? FLASH_TICKS : PAUSE_TICKS,
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] code,
  output phase_t        phase,
  output logic [CW-1:0] flashes_left
);
  localparam logic [TW-1:0] FLASH_LAST = TW'(FLASH_TICKS - 1);
  localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_TICKS - 1);

  logic [TW-1:0] timer;
  logic          phase_end;

  always_comb begin
    unique case (phase)
      PH_ON, PH_OFF: phase_end = (timer == FLASH_LAST);
      PH_PAUSE:      phase_end = (timer == PAUSE_LAST);
      default:       phase_end = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      timer        <= '0;
      flashes_left <= '0;
    end else if (tick) begin
      if (!phase_end) begin
        timer <= timer + 1'b1;
      end else begin
        timer <= '0;
        unique case (phase)
          PH_IDLE, PH_PAUSE: begin
            if (code != '0) begin
              phase        <= PH_ON;
              flashes_left <= code;
            end else begin
              phase <= PH_IDLE;
            end
          end
          PH_ON: phase <= PH_OFF;
          PH_OFF: begin
            if (flashes_left == CW'(1)) begin
              phase <= PH_PAUSE;
            end else begin
              phase        <= PH_ON;
              flashes_left <= flashes_left - 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fc_led_drive.sv
// Registered active-low drive from the sequencer phase and the steady-on request.
module fc_led_drive
  import fault_cadence_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  input  logic   steady_req,
  output logic   led_n
);
  logic lit;
  assign lit = (phase == PH_ON) || ((phase == PH_IDLE) && steady_req);

  always_ff @(posedge clk) begin
    if (rst) led_n <= 1'b1;
    else     led_n <= ~lit;
  end
endmodule

// File: rtl/fault_cadence_led.sv
module fault_cadence_led
  import fault_cadence_pkg::*;
#(
  parameter int NUM_FAULTS  = 5,
  parameter int FLASH_TICKS = 4,
  parameter int PAUSE_TICKS = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic [NUM_FAULTS-1:0] faults,
  input  logic                  ext_squelch,
  output logic                  led_n
);
  localparam int CW = $clog2(NUM_FAULTS + 1);

  logic [CW-1:0] code;
  logic          any_fault;
  phase_t        phase;
  logic [CW-1:0] flashes_left;
  logic          steady_req;

  fc_prio_enc #(.NUM_FAULTS(NUM_FAULTS)) u_enc (
    .faults    (faults),
    .code      (code),
    .any_fault (any_fault)
  );

  fc_cadence_seq #(
    .NUM_FAULTS  (NUM_FAULTS),
    .FLASH_TICKS (FLASH_TICKS),
    .PAUSE_TICKS (PAUSE_TICKS)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .code         (code),
    .phase        (phase),
    .flashes_left (flashes_left)
  );

  assign steady_req = ext_squelch && !any_fault;

  fc_led_drive u_drv (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .steady_req (steady_req),
    .led_n      (led_n)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker
  import fault_cadence_pkg::*;
#(
  parameter int NUM_FAULTS = 5,
  localparam int CW = $clog2(NUM_FAULTS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input phase_t        phase,
  input logic [CW-1:0] flashes_left,
  input logic [CW-1:0] code,
  input logic          any_fault,
  input logic          ext_squelch,
  input logic          led_n
);
  AST_RESET_DARK: assert property (@(posedge clk) rst |=> led_n); // R8

  AST_ON_LIT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ON) |=> !led_n); // R4

  AST_PAUSE_DARK: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAUSE) |=> led_n); // R10

  AST_STEADY_ON: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && ext_squelch && !any_fault) |=> !led_n); // R5

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == PH_IDLE && code != '0) |=> (phase == PH_ON && flashes_left == $past(code))); // R9

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(phase) && $stable(flashes_left))); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (flashes_left <= CW'(NUM_FAULTS))); // R2
endmodule

bind fault_cadence_led fc_checker #(.NUM_FAULTS(NUM_FAULTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick         (tick),
  .phase        (phase),
  .flashes_left (flashes_left),
  .code         (code),
  .any_fault    (any_fault),
  .ext_squelch  (ext_squelch),
  .led_n        (led_n)
);

// File: tb/fault_cadence_led_tb.sv
`timescale 1ns/1ps
module fault_cadence_led_tb;
  localparam int NF = 5;
  localparam int N  = 2;
  localparam int P  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [NF-1:0] faults = '0;
  logic          ext_squelch = 1'b0;
  logic          led_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  fault_cadence_led #(.NUM_FAULTS(NF), .FLASH_TICKS(N), .PAUSE_TICKS(P)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .faults(faults),
    .ext_squelch(ext_squelch), .led_n(led_n)
  );

  function automatic int code_of(logic [NF-1:0] f);
    int c = 0;
    for (int i = 0; i < NF; i++) if (f[i]) c = i + 1;
    return c;
  endfunction

  function automatic int period(int c);
    return c * 2 * N + P;
  endfunction

  // lit (1) in tick slot j of a burst cadence for count c
  function automatic logic burst_lit(int c, int j);
    int m = j % period(c);
    return (m < c * 2 * N) && ((m % (2 * N)) < N);
  endfunction

  task automatic chk(string req, logic act_n, logic exp_n);
    n_tests++;
    if (act_n !== exp_n) begin
      n_fail++;
      $display("FAIL %s: led_n actual=%b expected=%b at %0t", req, act_n, exp_n, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", led_n, 1'b1);
    rst = 1'b0;
  endtask

  // one tick, then settle; returns at a negedge well after the LED register updates
  task automatic step();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep(logic [NF-1:0] f, logic e);
    int c;
    int slots;
    string tag;
    faults = f;
    ext_squelch = e;
    do_reset();
    c = code_of(f);
    repeat (2) @(negedge clk);
    chk(c == 0 ? (e ? "R5" : "R6") : "R9", led_n, !(c == 0 && e));
    slots = (c == 0) ? 6 : 2 * period(c);
    for (int j = 0; j < slots; j++) begin
      step();
      if (c == 0) begin
        tag = e ? "R5" : "R6";
        chk(tag, led_n, !e);
      end else begin
        if ((j % period(c)) >= c * 2 * N) tag = e ? "R10" : "R4";
        else if ($countones(f) > 1) tag = "R3";
        else if (c == 5) tag = "R1";
        else tag = "R2";
        chk(tag, led_n, !burst_lit(c, j));
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // exhaustive sweep of fault patterns and override
    for (int f = 0; f < (1 << NF); f++) begin
      for (int e = 0; e < 2; e++) sweep(NF'(f), e[0]);
    end

    // R7: count changes mid-burst only after pause ends
    faults = 5'b10000; ext_squelch = 1'b0;
    do_reset();
    for (int j = 0; j < period(5) + 2 * period(1); j++) begin
      step();
      if (j == 3) faults = 5'b00001;
      if (j < period(5)) chk("R7", led_n, !burst_lit(5, j));
      else               chk("R7", led_n, !burst_lit(1, j - period(5)));
    end

    // R7/R10: faults cleared mid-burst with override on; steady only after pause
    faults = 5'b00100; ext_squelch = 1'b0;
    do_reset();
    for (int j = 0; j < period(3) + 4; j++) begin
      step();
      if (j == 1) begin faults = '0; ext_squelch = 1'b1; end
      if (j < period(3)) chk("R7", led_n, !burst_lit(3, j));
      else               chk("R5", led_n, 1'b0);
    end

    // R9: no ticks, no progress
    faults = 5'b00010; ext_squelch = 1'b0;
    do_reset();
    repeat (20) @(negedge clk);
    chk("R9", led_n, 1'b1);
    step();
    chk("R9", led_n, 1'b0);
    repeat (40) @(negedge clk);
    chk("R9", led_n, 1'b0);
    step();
    step();
    chk("R9", led_n, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule